// File: doc/BRIEF.md
# Floating-Point State Dump and Reinitialize Sequencer

This block owns the environment registers of a floating-point unit: control, status, tag, instruction pointer, data pointer and last opcode. On a save command it streams a complete state image out through a 16-bit memory write port. The image holds the environment words first and then the eight 80-bit stack registers. Once the last word has been accepted, the block forces its environment registers to their initialization constants. A core uses it for context switches, or to hand a clean unit to a called routine.

A save command carries four qualifiers: a waiting/non-waiting flag, a compact/wide image select, a lock-prefix flag and a base byte address. Two control-register bits (emulate, task-switched) and a memory-fault input can stop the save. Every stop is reported as a one-cycle fault pulse with a code. The sequencer holds off capture until the arithmetic pipeline reports idle, so the image reflects every operation issued before the save.

Top module: `fpst_dump_seq`

## Requirements
- R1: A save command is taken only while the sequencer is idle. A `save_req_i` pulse during draining, writing or the done cycle is ignored and causes no extra writes.
- R2: Words go out in index order i = 0, 1, ..., each to byte address base + 2*i. The compact image (`save_wide_i`=0) starts with 7 environment words: i0 control, i1 status, i2 tag, i3 ip[15:0], i4 opcode, i5 dp[15:0], i6 {dp[23:16], ip[23:16]}. The wide image (`save_wide_i`=1) starts with 14: i0 control, i2 status, i4 tag, i6 ip[15:0], i7 ip[31:16], i8 opcode, i10 dp[15:0], i11 dp[31:16], all others zero.
- R3: Forty stack words follow the E environment words (E = 7 or 14), so the total is 47 or 54. Word E+5k+j holds bits [16j+15:16j] of ST(k), where ST(k) is `stack_i[80k+79:80k]`. While `mem_valid_o` is high and `mem_ready_i` is low, address and data stay stable.
- R4: In the cycle after the final word is accepted, `done_o` is high for exactly one cycle. From that cycle the environment outputs read control 037Fh, status 0, tag FFFFh, and ip, dp and opcode 0.
- R5: The status word in the image carries the condition bits (status bits 8, 9, 10, 14) as they were held. After completion those bits read 0.
- R6: The waiting variant (`save_wait_i`=1) checks for a pending exception after draining. An exception is pending when some bit of status[5:0] is set while the same bit of control[5:0] is clear. If one is pending, the save stops with fault code 3 and nothing is written. The non-waiting variant saves regardless.
- R7: If `cr_emul_i` or `cr_tswitch_i` is set at the command, the save stops with fault code 1 and nothing is written.
- R8: If `save_lock_i` is set, the save stops with fault code 2 and nothing is written. This takes priority over R7.
- R9: While `arith_busy_i` is high after the command, nothing is written. The stack is sampled in the cycle in which `arith_busy_i` is seen low.
- R10: If `mem_fault_i` is high while `mem_valid_o` is high, that write is aborted even if `mem_ready_i` is also high. The save stops with fault code 4, no done pulse follows, and the environment registers keep their prior values.
- R11: `env_upd_i` loads the environment registers, except from the first write through the done cycle, when it is ignored. Reset sets the R4 values.
- R12: `fault_o` is a one-cycle pulse that comes one cycle after the deciding clock edge. `fault_code_o` is 0 whenever `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| env_upd_i | input | 1 | Load environment registers |
| env_ctrl_i | input | 16 | Control word to load |
| env_stat_i | input | 16 | Status word to load |
| env_tag_i | input | 16 | Tag word to load |
| env_ip_i | input | 32 | Instruction pointer to load |
| env_dp_i | input | 32 | Data pointer to load |
| env_op_i | input | 16 | Last opcode to load |
| ctrl_o | output | 16 | Current control word |
| stat_o | output | 16 | Current status word |
| tag_o | output | 16 | Current tag word |
| ip_o | output | 32 | Current instruction pointer |
| dp_o | output | 32 | Current data pointer |
| op_o | output | 16 | Current last opcode |
| stack_i | input | N_ST*80 | Stack registers, ST(k) at bits 80k+79:80k |
| arith_busy_i | input | 1 | Arithmetic pipeline busy |
| save_req_i | input | 1 | Save command |
| save_wait_i | input | 1 | Waiting variant |
| save_lock_i | input | 1 | Command carries lock prefix |
| save_wide_i | input | 1 | Wide image select |
| save_base_i | input | ADDR_W | Image base byte address |
| cr_emul_i | input | 1 | Emulate control bit |
| cr_tswitch_i | input | 1 | Task-switched control bit |
| mem_valid_o | output | 1 | Write word valid |
| mem_ready_i | input | 1 | Write word accepted |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | 16 | Write data |
| mem_fault_i | input | 1 | Memory fault on current write |
| done_o | output | 1 | Save complete, registers reinitialized |
| fault_o | output | 1 | Save stopped |
| fault_code_o | output | 3 | Stop cause |

## Verification
Two of the block's actions can meet on one clock edge: the commit of the final word, which also triggers reinitialization, and the abort by a memory fault. The bench sets the fault on the exact cycle the last word is shown, with ready held high. It then expects fault code 4, no done pulse, unchanged environment outputs and exactly one unconsumed word in its scoreboard. A second case asserts a fault partway through the image while environment updates and a repeated command arrive. That case checks the abort leaves the state untouched and that the ignored inputs left no trace.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam int WORD_W           = 16;
    localparam int REG_W            = 80;
    localparam int WORDS_PER_REG    = REG_W / WORD_W;
    localparam int ENV_WORDS_NARROW = 7;
    localparam int ENV_WORDS_WIDE   = 14;

    localparam logic [15:0] CTRL_INIT = 16'h037F;
    localparam logic [15:0] STAT_INIT = 16'h0000;
    localparam logic [15:0] TAG_INIT  = 16'hFFFF;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] stat;
        logic [15:0] tag;
        logic [31:0] ip;
        logic [31:0] dp;
        logic [15:0] op;
    } fenv_t;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_DNA  = 3'd1,
        FLT_UD   = 3'd2,
        FLT_MATH = 3'd3,
        FLT_MEM  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_DRAIN,
        SQ_WRITE,
        SQ_DONE
    } sq_state_e;

    function automatic fenv_t env_defaults();
        fenv_t e;
        e.ctrl = CTRL_INIT;
        e.stat = STAT_INIT;
        e.tag  = TAG_INIT;
        e.ip   = '0;
        e.dp   = '0;
        e.op   = '0;
        return e;
    endfunction

    function automatic logic pending_unmasked(input fenv_t e);
        return |(e.stat[5:0] & ~e.ctrl[5:0]);
    endfunction

    function automatic logic [15:0] env_word(input fenv_t e, input logic wide,
                                             input logic [3:0] i);
        logic [15:0] w;
        w = '0;
        if (!wide) begin
            case (i)
                4'd0: w = e.ctrl;
                4'd1: w = e.stat;
                4'd2: w = e.tag;
                4'd3: w = e.ip[15:0];
                4'd4: w = e.op;
                4'd5: w = e.dp[15:0];
                4'd6: w = {e.dp[23:16], e.ip[23:16]};
                default: w = '0;
            endcase
        end else begin
            case (i)
                4'd0:  w = e.ctrl;
                4'd2:  w = e.stat;
                4'd4:  w = e.tag;
                4'd6:  w = e.ip[15:0];
                4'd7:  w = e.ip[31:16];
                4'd8:  w = e.op;
                4'd10: w = e.dp[15:0];
                4'd11: w = e.dp[31:16];
                default: w = '0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/fpst_env_regs.sv
module fpst_env_regs
    import fpst_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  upd_i,
    input  fenv_t upd_env_i,
    input  logic  init_i,
    output fenv_t env_o
);

    fenv_t env_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || init_i) begin
            env_q <= env_defaults();
        end else if (upd_i) begin
            env_q <= upd_env_i;
        end
    end

    assign env_o = env_q;

    // R4: the cycle after a commit, all fields read their init constants
    a_r4_init_values: assert property (@(posedge clk_i) disable iff (rst_i)
        init_i |=> (env_o.ctrl == 16'h037F && env_o.stat == 16'h0 &&
                    env_o.tag == 16'hFFFF && env_o.ip == 32'h0 &&
                    env_o.dp == 32'h0 && env_o.op == 16'h0));

    // R11: without a load or commit the registers keep their contents
    a_r11_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!init_i && !upd_i) |=> $stable(env_o));

endmodule

// File: rtl/fpst_image_src.sv
module fpst_image_src
    import fpst_pkg::*;
#(
    parameter int N_ST  = 8,
    parameter int IDX_W = 6
) (
    input  logic                  clk_i,
    input  logic                  capture_i,
    input  fenv_t                 env_i,
    input  logic [N_ST*REG_W-1:0] stack_i,
    input  logic                  wide_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [WORD_W-1:0]     word_o,
    output logic                  last_o
);

    localparam int ST_WORDS = N_ST * WORDS_PER_REG;
    localparam int REL_W    = $clog2(ST_WORDS);

    fenv_t                 env_snap;
    logic [N_ST*REG_W-1:0] stk_snap;
    logic [WORD_W-1:0]     stk_words [ST_WORDS];
    logic [IDX_W-1:0]      env_n;
    logic [IDX_W-1:0]      rel;
    logic [REL_W-1:0]      rel_s;

    always_ff @(posedge clk_i) begin
        if (capture_i) begin
            env_snap <= env_i;
            stk_snap <= stack_i;
        end
    end

    // Word g of the stack area is bit slice 16g of the packed register file
    for (genvar g = 0; g < ST_WORDS; g++) begin : g_stk_word
        assign stk_words[g] = stk_snap[g*WORD_W +: WORD_W];
    end

    always_comb begin
        env_n  = wide_i ? IDX_W'(ENV_WORDS_WIDE) : IDX_W'(ENV_WORDS_NARROW);
        rel    = idx_i - env_n;
        rel_s  = rel[REL_W-1:0];
        last_o = (idx_i == env_n + IDX_W'(ST_WORDS - 1));
        if (idx_i < env_n) begin
            word_o = env_word(env_snap, wide_i, idx_i[3:0]);
        end else if (rel < IDX_W'(ST_WORDS)) begin
            word_o = stk_words[rel_s];
        end else begin
            word_o = '0;
        end
    end

endmodule

// File: rtl/fpst_seq_ctl.sv
module fpst_seq_ctl
    import fpst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_i,
    input  logic              wait_i,
    input  logic              lock_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              em_i,
    input  logic              ts_i,
    input  logic              arith_busy_i,
    input  logic              pending_i,
    input  logic              mem_ready_i,
    input  logic              mem_fault_i,
    input  logic              last_i,
    output logic              upd_ok_o,
    output logic              capture_o,
    output logic              wide_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              mem_valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              init_o,
    output logic              done_o,
    output logic              fault_o,
    output fault_e            fault_code_o
);

    sq_state_e         state_q;
    logic              wait_q;
    logic              wide_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic              fault_q;
    fault_e            code_q;

    always_comb begin
        upd_ok_o    = (state_q == SQ_IDLE) || (state_q == SQ_DRAIN);
        capture_o   = (state_q == SQ_DRAIN) && !arith_busy_i && !(wait_q && pending_i);
        mem_valid_o = (state_q == SQ_WRITE);
        init_o      = mem_valid_o && mem_ready_i && !mem_fault_i && last_i;
        done_o      = (state_q == SQ_DONE);
        mem_addr_o  = base_q + ADDR_W'({idx_q, 1'b0});
    end

    assign wide_o       = wide_q;
    assign idx_o        = idx_q;
    assign fault_o      = fault_q;
    assign fault_code_o = code_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SQ_IDLE;
            wait_q  <= 1'b0;
            wide_q  <= 1'b0;
            base_q  <= '0;
            idx_q   <= '0;
            fault_q <= 1'b0;
            code_q  <= FLT_NONE;
        end else begin
            fault_q <= 1'b0;
            code_q  <= FLT_NONE;
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_i) begin
                        wait_q <= wait_i;
                        wide_q <= wide_i;
                        base_q <= base_i;
                        if (lock_i) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_UD;
                        end else if (em_i || ts_i) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_DNA;
                        end else begin
                            state_q <= SQ_DRAIN;
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (!arith_busy_i) begin
                        if (wait_q && pending_i) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_MATH;
                            state_q <= SQ_IDLE;
                        end else begin
                            idx_q   <= '0;
                            state_q <= SQ_WRITE;
                        end
                    end
                end
                SQ_WRITE: begin
                    if (mem_fault_i) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_MEM;
                        state_q <= SQ_IDLE;
                    end else if (mem_ready_i) begin
                        if (last_i) begin
                            state_q <= SQ_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R3: accepted non-final word advances the address by one word
    a_r3_addr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && mem_ready_i && !mem_fault_i && !last_i) |=>
        (mem_valid_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

    // R3: a stalled word keeps its address
    a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && !mem_ready_i && !mem_fault_i) |=>
        (mem_valid_o && $stable(mem_addr_o)));

    // R4: done lasts one cycle
    a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R7: control-bit stop writes nothing
    a_r7_no_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_IDLE && cmd_i && !lock_i && (em_i || ts_i)) |=>
        (fault_o && !mem_valid_o));

    // R9: nothing goes out while the pipeline is busy
    a_r9_drain: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_DRAIN && arith_busy_i) |=> !mem_valid_o);

    // R10: a faulted write never leads to done
    a_r10_abort: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && mem_fault_i) |=>
        (!done_o && fault_o && fault_code_o == FLT_MEM));

    // R12: fault is a single-cycle pulse, outputs mutually exclusive
    a_r12_fault_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o |=> !fault_o);
    a_r12_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({done_o, fault_o, mem_valid_o}));

endmodule

// File: rtl/fpst_dump_seq.sv
module fpst_dump_seq
    import fpst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_ST   = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  env_upd_i,
    input  logic [15:0]           env_ctrl_i,
    input  logic [15:0]           env_stat_i,
    input  logic [15:0]           env_tag_i,
    input  logic [31:0]           env_ip_i,
    input  logic [31:0]           env_dp_i,
    input  logic [15:0]           env_op_i,
    output logic [15:0]           ctrl_o,
    output logic [15:0]           stat_o,
    output logic [15:0]           tag_o,
    output logic [31:0]           ip_o,
    output logic [31:0]           dp_o,
    output logic [15:0]           op_o,
    input  logic [N_ST*80-1:0]    stack_i,
    input  logic                  arith_busy_i,
    input  logic                  save_req_i,
    input  logic                  save_wait_i,
    input  logic                  save_lock_i,
    input  logic                  save_wide_i,
    input  logic [ADDR_W-1:0]     save_base_i,
    input  logic                  cr_emul_i,
    input  logic                  cr_tswitch_i,
    output logic                  mem_valid_o,
    input  logic                  mem_ready_i,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [15:0]           mem_data_o,
    input  logic                  mem_fault_i,
    output logic                  done_o,
    output logic                  fault_o,
    output logic [2:0]            fault_code_o
);

    localparam int MAX_WORDS = ENV_WORDS_WIDE + N_ST * WORDS_PER_REG;
    localparam int IDX_W     = $clog2(MAX_WORDS + 1);

    fenv_t            env_in;
    fenv_t            env_cur;
    logic             upd_ok;
    logic             capture;
    logic             wide_l;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             init;
    fault_e           code;

    always_comb begin
        env_in.ctrl = env_ctrl_i;
        env_in.stat = env_stat_i;
        env_in.tag  = env_tag_i;
        env_in.ip   = env_ip_i;
        env_in.dp   = env_dp_i;
        env_in.op   = env_op_i;
    end

    fpst_env_regs u_env (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .upd_i     (env_upd_i && upd_ok),
        .upd_env_i (env_in),
        .init_i    (init),
        .env_o     (env_cur)
    );

    fpst_seq_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .cmd_i        (save_req_i),
        .wait_i       (save_wait_i),
        .lock_i       (save_lock_i),
        .wide_i       (save_wide_i),
        .base_i       (save_base_i),
        .em_i         (cr_emul_i),
        .ts_i         (cr_tswitch_i),
        .arith_busy_i (arith_busy_i),
        .pending_i    (pending_unmasked(env_cur)),
        .mem_ready_i  (mem_ready_i),
        .mem_fault_i  (mem_fault_i),
        .last_i       (last),
        .upd_ok_o     (upd_ok),
        .capture_o    (capture),
        .wide_o       (wide_l),
        .idx_o        (idx),
        .mem_valid_o  (mem_valid_o),
        .mem_addr_o   (mem_addr_o),
        .init_o       (init),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .fault_code_o (code)
    );

    fpst_image_src #(.N_ST(N_ST), .IDX_W(IDX_W)) u_img (
        .clk_i     (clk_i),
        .capture_i (capture),
        .env_i     (env_cur),
        .stack_i   (stack_i),
        .wide_i    (wide_l),
        .idx_i     (idx),
        .word_o    (mem_data_o),
        .last_o    (last)
    );

    assign ctrl_o       = env_cur.ctrl;
    assign stat_o       = env_cur.stat;
    assign tag_o        = env_cur.tag;
    assign ip_o         = env_cur.ip;
    assign dp_o         = env_cur.dp;
    assign op_o         = env_cur.op;
    assign fault_code_o = code;

    // R5: completion leaves the condition bits clear
    a_r5_cond_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (stat_o[14] == 1'b0 && stat_o[10:8] == 3'b000));

endmodule

// File: tb/fpst_dump_seq_tb_top.sv
module fpst_dump_seq_tb_top;
    import fpst_pkg::*;

    logic         clk = 1'b0;
    logic         rst;
    logic         env_upd;
    logic [15:0]  e_ctrl, e_stat, e_tag, e_op;
    logic [31:0]  e_ip, e_dp;
    logic [15:0]  ctrl_o, stat_o, tag_o, op_o;
    logic [31:0]  ip_o, dp_o;
    logic [639:0] stack;
    logic         busy, req, s_wait, s_lock, s_wide, em, ts;
    logic [31:0]  base;
    logic         mvalid, mready, mfault;
    logic [31:0]  maddr;
    logic [15:0]  mdata;
    logic         done, fault;
    logic [2:0]   fcode;

    int n_chk = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    int cyc = 0;
    bit ready_all = 1'b1;
    bit fault_arm = 1'b0;
    int fault_at = 0;
    int rcnt = 0;
    logic [47:0] exp_q[$];

    always #2 clk = ~clk;

    fpst_dump_seq dut_i (
        .clk_i(clk), .rst_i(rst), .env_upd_i(env_upd),
        .env_ctrl_i(e_ctrl), .env_stat_i(e_stat), .env_tag_i(e_tag),
        .env_ip_i(e_ip), .env_dp_i(e_dp), .env_op_i(e_op),
        .ctrl_o(ctrl_o), .stat_o(stat_o), .tag_o(tag_o),
        .ip_o(ip_o), .dp_o(dp_o), .op_o(op_o),
        .stack_i(stack), .arith_busy_i(busy),
        .save_req_i(req), .save_wait_i(s_wait), .save_lock_i(s_lock),
        .save_wide_i(s_wide), .save_base_i(base),
        .cr_emul_i(em), .cr_tswitch_i(ts),
        .mem_valid_o(mvalid), .mem_ready_i(mready), .mem_addr_o(maddr),
        .mem_data_o(mdata), .mem_fault_i(mfault),
        .done_o(done), .fault_o(fault), .fault_code_o(fcode)
    );

    task automatic chk(input bit ok, input string req_tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    // Memory-side driver: ready pattern and fault injection
    always @(posedge clk) begin
        #1;
        rcnt++;
        mready = ready_all ? 1'b1 : ((rcnt % 3) != 0);
        mfault = fault_arm && (acc_cnt == fault_at);
    end

    // Scoreboard monitor (R2, R3)
    always @(negedge clk) begin
        if (!rst && mvalid && mready && !mfault) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected write", {32'h0, maddr}, 64'h0);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                chk({maddr, mdata} == e, "R2/R3 image word", {16'h0, maddr, mdata}, {16'h0, e});
            end
            acc_cnt++;
        end
    end

    task automatic push_image(input fenv_t e, input logic [639:0] st, input bit wide,
                              input logic [31:0] b);
        logic [15:0] w[$];
        if (wide)
            w = '{e.ctrl, 16'h0, e.stat, 16'h0, e.tag, 16'h0, e.ip[15:0], e.ip[31:16],
                  e.op, 16'h0, e.dp[15:0], e.dp[31:16], 16'h0, 16'h0};
        else
            w = '{e.ctrl, e.stat, e.tag, e.ip[15:0], e.op, e.dp[15:0],
                  {e.dp[23:16], e.ip[23:16]}};
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 5; j++)
                w.push_back(st[80*k + 16*j +: 16]);
        for (int i = 0; i < w.size(); i++)
            exp_q.push_back({b + 32'(2*i), w[i]});
    endtask

    task automatic load_env(input fenv_t e);
        @(posedge clk); #1;
        e_ctrl = e.ctrl; e_stat = e.stat; e_tag = e.tag;
        e_ip = e.ip; e_dp = e.dp; e_op = e.op; env_upd = 1'b1;
        @(posedge clk); #1;
        env_upd = 1'b0;
    endtask

    function automatic fenv_t cur_env();
        fenv_t e;
        e.ctrl = ctrl_o; e.stat = stat_o; e.tag = tag_o;
        e.ip = ip_o; e.dp = dp_o; e.op = op_o;
        return e;
    endfunction

    task automatic do_save(input bit w, input bit wide, input bit lk, input bit e_m,
                           input bit t_s, input logic [31:0] b,
                           output bit got_done, output logic [2:0] code);
        got_done = 1'b0;
        code = 3'd0;
        acc_cnt = 0;
        @(posedge clk); #1;
        s_wait = w; s_wide = wide; s_lock = lk; em = e_m; ts = t_s; base = b;
        req = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                break;
            end
            if (fault) begin
                code = fcode;
                break;
            end
        end
        em = 1'b0; ts = 1'b0; s_lock = 1'b0;
    endtask

    task automatic check_defaults(input string tag);
        chk(ctrl_o == 16'h037F, tag, ctrl_o, 16'h037F);
        chk(stat_o == 16'h0, tag, stat_o, 0);
        chk(tag_o == 16'hFFFF, tag, tag_o, 16'hFFFF);
        chk(ip_o == 0 && dp_o == 0 && op_o == 0, tag, {ip_o, dp_o}, 0);
    endtask

    task automatic no_write_window(input string tag, input int n);
        int seen = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (mvalid) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        fenv_t ea, eb, ec, snap;
        logic [639:0] sa, sb;
        bit gd;
        logic [2:0] cd;

        rst = 1'b1; env_upd = 0; req = 0; busy = 0; s_wait = 0; s_lock = 0;
        s_wide = 0; em = 0; ts = 0; base = 0; mready = 1; mfault = 0;
        e_ctrl = 0; e_stat = 0; e_tag = 0; e_ip = 0; e_dp = 0; e_op = 0;
        for (int i = 0; i < 20; i++) stack[32*i +: 32] = 32'hA5000000 + 32'(i * 32'h01010101);
        sa = stack;
        for (int i = 0; i < 20; i++) sb[32*i +: 32] = 32'h3C000000 ^ 32'(i * 32'h00237011);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R11/R4: reset state
        check_defaults("R11 reset value");
        chk(!mvalid && !done && !fault, "R12 idle outputs", {mvalid, done, fault}, 0);

        // R2, R3, R4: wide non-waiting save, always ready
        ea = '{ctrl: 16'h0372, stat: 16'h3800, tag: 16'h5A0F, ip: 32'h12345678,
               dp: 32'h9ABCDEF0, op: 16'h0123};
        load_env(ea);
        chk(cur_env() == ea, "R11 load", cur_env(), ea);
        push_image(ea, sa, 1'b1, 32'h0000_1000);
        do_save(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1000, gd, cd);
        chk(gd, "R4 done seen", gd, 1);
        chk(exp_q.size() == 0, "R3 all 54 words", exp_q.size(), 0);
        check_defaults("R4 init after save");
        @(negedge clk);
        chk(!done, "R4 done single cycle", done, 0);

        // R5, R3: compact save with condition bits, stalling ready
        eb = '{ctrl: 16'h037F, stat: 16'h4783, tag: 16'h0000, ip: 32'hCAFE_BEEF,
               dp: 32'h0055_AA11, op: 16'h07FF};
        load_env(eb);
        ready_all = 1'b0;
        push_image(eb, sa, 1'b0, 32'h0002_0000);
        do_save(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0000, gd, cd);
        chk(gd, "R5 masked wait saves", gd, 1);
        chk(exp_q.size() == 0, "R3 all 47 words", exp_q.size(), 0);
        chk(stat_o[14] == 0 && stat_o[10:8] == 0, "R5 cond bits cleared", stat_o, 0);
        ready_all = 1'b1;

        // R6: waiting variant with unmasked pending exception
        ec = '{ctrl: 16'h037E, stat: 16'h0001, tag: 16'h1111, ip: 32'h1, dp: 32'h2, op: 16'h3};
        load_env(ec);
        do_save(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h100, gd, cd);
        chk(!gd && cd == 3'd3, "R6 math fault code", cd, 3);
        chk(cur_env() == ec, "R6 env untouched", cur_env(), ec);
        @(negedge clk);
        chk(!fault && fcode == 0, "R12 fault single pulse", {fault, fcode}, 0);
        // R6: non-waiting ignores the pending exception
        push_image(ec, sa, 1'b0, 32'h200);
        do_save(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h200, gd, cd);
        chk(gd, "R6 non-waiting saves", gd, 1);

        // R7: emulate bit, then task-switched bit
        load_env(ea);
        do_save(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h300, gd, cd);
        chk(cd == 3'd1, "R7 emulate fault", cd, 1);
        do_save(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h300, gd, cd);
        chk(cd == 3'd1, "R7 task-switched fault", cd, 1);
        // R8: lock wins over emulate
        do_save(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h300, gd, cd);
        chk(cd == 3'd2, "R8 lock fault priority", cd, 2);
        no_write_window("R7 R8 nothing written", 4);
        chk(cur_env() == ea, "R7 env untouched", cur_env(), ea);

        // R9: busy pipeline delays capture; stack seen at busy drop is saved
        busy = 1'b1;
        stack = sa;
        push_image(ea, sb, 1'b1, 32'h400);
        fork
            do_save(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h400, gd, cd);
            begin
                int seen = 0;
                repeat (2) @(posedge clk);
                for (int c = 0; c < 6; c++) begin
                    @(negedge clk);
                    if (mvalid) seen++;
                end
                chk(seen == 0, "R9 no write while busy", seen, 0);
                @(posedge clk); #1;
                busy = 1'b0;
                stack = sb;
            end
        join
        chk(gd && exp_q.size() == 0, "R9 image after drain", exp_q.size(), 0);

        // R10, R11, R1: mid-image fault with env update and repeat command
        load_env(ea);
        fault_arm = 1'b1; fault_at = 20;
        push_image(ea, sb, 1'b1, 32'h800);
        fork
            do_save(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h800, gd, cd);
            begin
                repeat (8) @(posedge clk); #1;
                env_upd = 1'b1; e_ctrl = 16'hDEAD; e_stat = 16'hBEEF;
                req = 1'b1;
                @(posedge clk); #1;
                env_upd = 1'b0; req = 1'b0;
            end
        join
        fault_arm = 1'b0;
        chk(!gd && cd == 3'd4, "R10 memory fault code", cd, 4);
        chk(exp_q.size() == 34, "R10 words left at abort", exp_q.size(), 34);
        chk(cur_env() == ea, "R11 env unchanged by ignored update", cur_env(), ea);
        exp_q.delete();
        no_write_window("R1 repeat command ignored", 6);

        // R10: fault coincides with final word accept
        fault_arm = 1'b1; fault_at = 53;
        push_image(ea, sb, 1'b1, 32'hC00);
        do_save(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hC00, gd, cd);
        fault_arm = 1'b0;
        chk(!gd && cd == 3'd4, "R10 fault beats last accept", {gd, cd}, 4);
        chk(exp_q.size() == 1, "R10 last word not counted", exp_q.size(), 1);
        snap = cur_env();
        chk(snap == ea, "R10 no reinit", snap, ea);
        exp_q.delete();
        no_write_window("R10 quiet after abort", 4);

        // R1: command during a save is ignored (only one image appears)
        push_image(ea, sb, 1'b0, 32'h1400);
        fork
            do_save(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1400, gd, cd);
            begin
                repeat (15) @(posedge clk); #1;
                req = 1'b1;
                @(posedge clk); #1;
                req = 1'b0;
            end
        join
        chk(gd, "R1 first save completes", gd, 1);
        no_write_window("R1 no second image", 10);
        check_defaults("R4 init after compact save");

        finish_run();
    end

endmodule